// File: doc/BRIEF.md
# Limit-Wrap Interval Timer Bank

The block holds one master interval timer and a number of per-processor interval timers behind a simple read/write register port. All timers share a prescaler that emits one strobe every `PRESCALE` clocks (one microsecond in a typical setup). On each strobe, an enabled timer with a nonzero limit advances its counter. When the advanced value would reach the programmed limit, the counter returns to 1 instead of 0 and a sticky limit-reached flag is set. A period of N strobes therefore takes a limit of N+1.

The master timer's flag is fanned out as a level-10 request to every processor. Each per-processor timer drives a level-14 request to its own processor and to no other. Software clears a request by reading the timer's limit register. It can move a limit without disturbing a pending request by writing the keep-state limit register.

Top module: `lwrap_timer_bank`

## Requirements
- R1: On a strobe where the running timer's counter plus one is greater than or equal to its limit, the counter becomes 1 and the flag is set. Otherwise the counter increments by one. Flags therefore rise every limit-1 strobes.
- R2: The prescaler strobe occurs once every `PRESCALE` clocks, first on the `PRESCALE`-th clock after reset. Counters change only on strobes.
- R3: The master timer's flag drives every bit of `irq_lvl10` with the same value.
- R4: Bit k of `irq_lvl14` equals the flag of per-processor timer k and does not depend on any other timer.
- R5: Limit and count words carry the flag in bit 31 and the value in bits 30..10. Bits 9..0 read as zero.
- R6: Reading offset 0 (limit) clears the flag. If a strobe sets the flag in the same cycle, the flag stays set.
- R7: Writing offset 0 loads the limit from bits 30..10, sets the counter to 1 and clears the flag.
- R8: Writing offset 8 loads the limit and leaves the counter and flag unchanged. Reading offset 8 returns the limit word and does not clear the flag.
- R9: A limit of 0 stops the counter, so the timer never raises its flag.
- R10: At offset 12, bit 0 is a run enable. It resets to 1, reads back in bit 0 with the other bits zero, and when it is 0 the counter holds.
- R11: After reset, per-processor limits read 0x009C4000, the master limit reads 0, counters are 1 and flags are clear.
- R12: Decoding and reads work as follows:
  - `addr[ADDR_W-1:4]` picks the timer: k for per-processor timer k, `NUM_CPUS` for the master. `addr[3:2]` picks the offset.
  - A read returns its word in `rdata` with `rvalid` high on the next cycle.
  - Reading an unmapped timer returns 0.
  - Writes to offset 4 (count) are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe for the addressed register |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | ADDR_W | Byte address: timer index and register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after `rd_en` |
| rvalid | output | 1 | High for one cycle when `rdata` holds a read result |
| irq_lvl10 | output | NUM_CPUS | Master timer request, one copy per processor |
| irq_lvl14 | output | NUM_CPUS | Per-processor timer request, one bit per processor |

## Verification
The properties assume that `rd_en` and `wr_en` are never high in the same cycle. Under that assumption, a limit read or limit write in a non-strobe cycle leaves the request low on the next cycle. The stimulus issues at most one bus operation per cycle, so it never asserts both strobes. Random limits stay small so that many wraps happen within the run. Directed cases cover a zero limit, a stopped timer, the keep-state write, writes to the count register and unmapped addresses.

// File: rtl/lwrap_timer_pkg.sv
package lwrap_timer_pkg;

    // Register word layout: flag on top, value field, zero low bits
    localparam int VAL_W    = 21;
    localparam int VAL_LSB  = 10;
    localparam int WORD_W   = 32;

    typedef enum logic [1:0] {
        OFF_LIMIT      = 2'd0,
        OFF_COUNT      = 2'd1,
        OFF_LIMIT_KEEP = 2'd2,
        OFF_CTRL       = 2'd3
    } reg_off_e;

    typedef struct packed {
        logic [VAL_W-1:0] limit;
        logic [VAL_W-1:0] count;
        logic             flag;
        logic             run;
    } tmr_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
        logic              rvalid;
    } bus_state_t;

    function automatic logic [WORD_W-1:0] pack_word(input logic f, input logic [VAL_W-1:0] v);
        return {f, v, {VAL_LSB{1'b0}}};
    endfunction

endpackage

// File: rtl/lwrap_tick_gen.sv
module lwrap_tick_gen #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] pc_d, pc_q;

    always_comb begin
        tick = (pc_q == LAST);
        pc_d = tick ? '0 : pc_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end
endmodule

// File: rtl/lwrap_timer_unit.sv
module lwrap_timer_unit
    import lwrap_timer_pkg::*;
#(
    parameter logic [VAL_W-1:0] RST_LIMIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              sel,
    input  logic              rd_en,
    input  logic              wr_en,
    input  reg_off_e          off,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rword,
    output logic              irq
);
    tmr_state_t st_d, st_q;
    logic [VAL_W-1:0] wval;
    logic [VAL_W:0]   nxt_cnt;
    logic             unused_bits;

    assign wval        = wdata[VAL_LSB +: VAL_W];
    assign unused_bits = ^{wdata[WORD_W-1], wdata[VAL_LSB-1:1]};
    assign nxt_cnt     = {1'b0, st_q.count} + 1'b1;

    always_comb begin
        st_d = st_q;
        // a limit read clears first, so a wrap in the same cycle wins
        if (sel && rd_en && off == OFF_LIMIT)
            st_d.flag = 1'b0;
        if (tick && st_q.run && st_q.limit != '0) begin
            if (nxt_cnt >= {1'b0, st_q.limit}) begin
                st_d.count = VAL_W'(1);
                st_d.flag  = 1'b1;
            end else begin
                st_d.count = nxt_cnt[VAL_W-1:0];
            end
        end
        if (sel && wr_en) begin
            unique case (off)
                OFF_LIMIT: begin
                    st_d.limit = wval;
                    st_d.count = VAL_W'(1);
                    st_d.flag  = 1'b0;
                end
                OFF_LIMIT_KEEP: st_d.limit = wval;
                OFF_CTRL:       st_d.run   = wdata[0];
                default:        ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.limit <= RST_LIMIT;
            st_q.count <= VAL_W'(1);
            st_q.flag  <= 1'b0;
            st_q.run   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (off)
            OFF_LIMIT, OFF_LIMIT_KEEP: rword = pack_word(st_q.flag, st_q.limit);
            OFF_COUNT:                 rword = pack_word(st_q.flag, st_q.count);
            default:                   rword = {{(WORD_W-1){1'b0}}, st_q.run};
        endcase
    end

    assign irq = st_q.flag;
endmodule

// File: rtl/lwrap_timer_bank.sv
module lwrap_timer_bank
    import lwrap_timer_pkg::*;
#(
    parameter int NUM_CPUS = 2,
    parameter int PRESCALE = 4,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WORD_W-1:0]   wdata,
    output logic [WORD_W-1:0]   rdata,
    output logic                rvalid,
    output logic [NUM_CPUS-1:0] irq_lvl10,
    output logic [NUM_CPUS-1:0] irq_lvl14
);
    localparam int BLK_W  = ADDR_W - 4;
    localparam int N_TMR  = NUM_CPUS + 1;
    localparam logic [VAL_W-1:0] CPU_RST_LIMIT = VAL_W'(32'h009C_4000 >> VAL_LSB);

    logic               tick;
    logic [BLK_W-1:0]   blk;
    reg_off_e           off;
    logic [N_TMR-1:0]   sel;
    logic [N_TMR-1:0]   flag;
    logic [WORD_W-1:0]  rword [N_TMR];
    bus_state_t         bus_d, bus_q;
    logic               unused_addr;

    assign blk         = addr[ADDR_W-1:4];
    assign off         = reg_off_e'(addr[3:2]);
    assign unused_addr = ^addr[1:0];

    lwrap_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        assign sel[i] = (blk == BLK_W'(i));
        lwrap_timer_unit #(
            .RST_LIMIT((i < NUM_CPUS) ? CPU_RST_LIMIT : '0)
        ) u_unit (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .sel   (sel[i]),
            .rd_en (rd_en),
            .wr_en (wr_en),
            .off   (off),
            .wdata (wdata),
            .rword (rword[i]),
            .irq   (flag[i])
        );
    end

    always_comb begin
        bus_d.rvalid = rd_en;
        bus_d.rdata  = bus_q.rdata;
        if (rd_en) begin
            bus_d.rdata = '0;
            for (int i = 0; i < N_TMR; i++)
                if (sel[i]) bus_d.rdata = rword[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    assign rdata     = bus_q.rdata;
    assign rvalid    = bus_q.rvalid;
    assign irq_lvl10 = {NUM_CPUS{flag[NUM_CPUS]}};
    assign irq_lvl14 = flag[NUM_CPUS-1:0];
endmodule

// File: rtl/lwrap_timer_bank_chk.sv
module lwrap_timer_bank_chk #(
    parameter int NUM_CPUS = 2,
    parameter int PRESCALE = 4,
    parameter int ADDR_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rd_en,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic                rvalid,
    input logic [NUM_CPUS-1:0] irq_lvl10,
    input logic [NUM_CPUS-1:0] irq_lvl14,
    input logic                tick
);
    logic cpu0_limit;
    assign cpu0_limit = (addr[ADDR_W-1:2] == '0);

    // input assumption: one bus operation per cycle
    a_bus_one_op: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

    a_r1_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_lvl14[0]) |-> $past(tick));

    a_r3_master_fanout: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(irq_lvl10) == 0) || ($countones(irq_lvl10) == NUM_CPUS));

    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cpu0_limit && !tick) |=> !irq_lvl14[0]);

    a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cpu0_limit) |=> !irq_lvl14[0]);

    a_r12_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);

    a_r12_rvalid_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(rd_en));

    if (PRESCALE > 1) begin : g_gap
        a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
    end
endmodule

bind lwrap_timer_bank lwrap_timer_bank_chk #(
    .NUM_CPUS(NUM_CPUS), .PRESCALE(PRESCALE), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .rvalid(rvalid), .irq_lvl10(irq_lvl10), .irq_lvl14(irq_lvl14), .tick(tick)
);

// File: tb/lwrap_timer_bank_bench.sv
module lwrap_timer_bank_bench;
    localparam int NC = 2;
    localparam int P  = 4;
    localparam int AW = 8;
    localparam int CLK_PERIOD = 10;
    localparam int NT = NC + 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rd_en = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic rvalid;
    logic [NC-1:0] irq_lvl10, irq_lvl14;

    int n_tests = 0, n_fail = 0, cyc = 0;

    // reference model
    logic [20:0] m_lim [NT];
    logic [20:0] m_cnt [NT];
    logic        m_flag[NT];
    logic        m_run [NT];
    int          m_pc;
    logic [31:0] m_rdata;
    logic        m_rvalid;

    always #(CLK_PERIOD/2) clk = ~clk;

    lwrap_timer_bank #(.NUM_CPUS(NC), .PRESCALE(P), .ADDR_W(AW)) u_lwrap_timer_bank (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .irq_lvl10(irq_lvl10), .irq_lvl14(irq_lvl14)
    );

    function automatic logic [AW-1:0] mk_addr(input int blk, input int off);
        return AW'(blk * 16 + off * 4);
    endfunction

    function automatic logic [31:0] ref_word(input int t, input int off);
        if (t >= NT) return 32'h0;
        case (off)
            0, 2: return {m_flag[t], m_lim[t], 10'b0};
            1:    return {m_flag[t], m_cnt[t], 10'b0};
            default: return {31'b0, m_run[t]};
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int t = 0; t < NT; t++) begin
            m_lim[t]  = (t < NC) ? 21'h2710 : 21'h0;
            m_cnt[t]  = 21'd1;
            m_flag[t] = 1'b0;
            m_run[t]  = 1'b1;
        end
        m_pc = 0; m_rdata = 0; m_rvalid = 0;
    endtask

    task automatic model_edge(input logic r, input logic w, input logic [AW-1:0] a, input logic [31:0] d);
        int blk = int'(a[AW-1:4]);
        int off = int'(a[3:2]);
        logic tk = (m_pc == P - 1);
        m_pc = tk ? 0 : m_pc + 1;
        m_rvalid = r;
        if (r) m_rdata = ref_word(blk, off);
        for (int t = 0; t < NT; t++) begin
            if (r && blk == t && off == 0) m_flag[t] = 1'b0;
            if (tk && m_run[t] && m_lim[t] != 0) begin
                if ({1'b0, m_cnt[t]} + 22'd1 >= {1'b0, m_lim[t]}) begin
                    m_cnt[t] = 21'd1; m_flag[t] = 1'b1;
                end else m_cnt[t] = m_cnt[t] + 21'd1;
            end
            if (w && blk == t) begin
                if (off == 0) begin m_lim[t] = d[30:10]; m_cnt[t] = 21'd1; m_flag[t] = 1'b0; end
                else if (off == 2) m_lim[t] = d[30:10];
                else if (off == 3) m_run[t] = d[0];
            end
        end
    endtask

    task automatic compare();
        for (int k = 0; k < NC; k++)
            check(irq_lvl14[k] == m_flag[k], "R4 per-cpu request", 32'(irq_lvl14[k]), 32'(m_flag[k]));
        check(irq_lvl10 == {NC{m_flag[NC]}}, "R3 master fanout", 32'(irq_lvl10), 32'({NC{m_flag[NC]}}));
        check(rvalid == m_rvalid, "R12 rvalid", 32'(rvalid), 32'(m_rvalid));
        if (m_rvalid) check(rdata == m_rdata, "R5 read word", rdata, m_rdata);
    endtask

    task automatic step(input logic r, input logic w, input logic [AW-1:0] a, input logic [31:0] d);
        rd_en = r; wr_en = w; addr = a; wdata = d;
        @(posedge clk);
        model_edge(r, w, a, d);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0);
    endtask

    task automatic rd(input int blk, input int off);
        step(1'b1, 1'b0, mk_addr(blk, off), '0);
    endtask

    task automatic wr(input int blk, input int off, input logic [31:0] d);
        step(1'b0, 1'b1, mk_addr(blk, off), d);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_tests++; n_fail++;
                $display("FAIL watchdog actual=%0d expected<150000", cyc);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin : main
        int last_rise, gap, seen;
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(negedge clk);
        check(irq_lvl14 == 0 && irq_lvl10 == 0, "R11 reset requests", 32'({irq_lvl10, irq_lvl14}), 0);
        rst_n = 1'b1;

        // R11 reset values
        rd(0, 2); check(rdata == 32'h009C_4000, "R11 cpu limit", rdata, 32'h009C_4000);
        rd(NC, 0); check(rdata == 32'h0, "R11 master limit", rdata, 0);
        rd(1, 1); check(rdata == 32'h0000_0400, "R11 count one", rdata, 32'h400);
        rd(0, 3); check(rdata == 32'h1, "R10 run resets to 1", rdata, 1);

        // R1/R2 period: limit 5 -> rise every 4 strobes = 16 clocks
        wr(0, 0, 32'd5 << 10);
        last_rise = -1; seen = 0; gap = 0;
        for (int i = 0; i < 80 && seen < 3; i++) begin
            if (irq_lvl14[0]) begin
                if (last_rise >= 0) begin
                    gap = i - last_rise;
                    check(gap == 4 * P, "R1 R2 wrap period", gap, 4 * P);
                end
                last_rise = i; seen++;
                rd(0, 0); // R6 clear by limit read
                check(irq_lvl14[0] == 1'b0, "R6 read clears", 32'(irq_lvl14[0]), 0);
            end else idle(1);
        end
        check(seen == 3, "R1 rises seen", seen, 3);

        // R8 keep-state limit write
        idle(4 * P + 2);
        check(irq_lvl14[0] == 1'b1, "R8 flag pending", 32'(irq_lvl14[0]), 1);
        wr(0, 2, 32'd9 << 10);
        check(irq_lvl14[0] == 1'b1, "R8 flag kept", 32'(irq_lvl14[0]), 1);
        rd(0, 2); check(rdata[30:10] == 21'd9 && rdata[31], "R8 limit loaded", rdata, {1'b1, 21'd9, 10'b0});
        check(irq_lvl14[0] == 1'b1, "R8 read keeps flag", 32'(irq_lvl14[0]), 1);

        // R7 normal write resets count and flag
        wr(0, 0, 32'd7 << 10);
        rd(0, 1); check(rdata[31] == 1'b0 && rdata[30:10] <= 21'd2, "R7 count restart", rdata, 32'h400);

        // R9 zero limit
        wr(1, 0, 32'h0);
        idle(20 * P);
        rd(1, 1); check(rdata == 32'h0000_0400, "R9 count held", rdata, 32'h400);
        check(irq_lvl14[1] == 1'b0, "R9 no request", 32'(irq_lvl14[1]), 0);

        // R10 stopped timer holds
        wr(1, 0, 32'd3 << 10);
        wr(1, 3, 32'hFFFF_FFFE);
        rd(1, 3); check(rdata == 32'h0, "R10 run readback", rdata, 0);
        rd(1, 1); gap = int'(rdata[30:10]);
        idle(10 * P);
        rd(1, 1); check(int'(rdata[30:10]) == gap, "R10 count held", rdata[30:10], gap);
        wr(1, 3, 32'h1);

        // R12 unmapped read and ignored count write
        rd(7, 0); check(rdata == 32'h0, "R12 unmapped", rdata, 0);
        wr(NC, 1, 32'hFFFF_FC00);
        rd(NC, 1); check(rdata == 32'h0000_0400, "R12 count write ignored", rdata, 32'h400);

        // R3 master fires to all
        wr(NC, 0, 32'd2 << 10);
        idle(2 * P);
        check(irq_lvl10 == '1, "R3 master to all", 32'(irq_lvl10), 32'({NC{1'b1}}));

        // R5 low bits zero even with junk written
        wr(0, 2, 32'hFFFF_FFFF);
        rd(0, 2); check(rdata[9:0] == 10'h0, "R5 low bits zero", rdata[9:0], 0);

        // random phase, one bus op per cycle
        for (int i = 0; i < 4000; i++) begin
            int sel = int'($urandom_range(0, 9));
            int blk = int'($urandom_range(0, NT));
            int off = int'($urandom_range(0, 3));
            logic [31:0] d = {1'($urandom), 21'($urandom_range(0, 12)), 10'($urandom)};
            if (off == 3) d[0] = ($urandom_range(0, 7) != 0);
            if (sel < 2)      step(1'b1, 1'b0, mk_addr(blk, off), '0);
            else if (sel < 3) step(1'b0, 1'b1, mk_addr(blk, off), d);
            else              step(1'b0, 1'b0, '0, '0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule